// File: doc/BRIEF.md
# Deferred Schedule Enable Gate

This block decides when the asynchronous list walker may use the list base address. Software writes a single enable bit through a command-register write strobe. That written value is not acted on straight away. The block holds it until the walker raises a one-cycle fetch-point pulse, which marks the moment the walker is about to load the next queue head. Only at that pulse does the written value become the effective enable.

The effective enable drives two outputs. The first is the walk-permission signal, which the walker obeys. The second is a status bit, which software polls after a write until it matches the value written. A pending flag reports that a written value is still waiting for its boundary.

Reset is asynchronous and active-low. The internal reset is released synchronously, a parameter-set number of clock edges after the external reset rises.

Top module: `sched_enable_gate`

## Requirements
- R1: An asserted `arst_n` (0) clears `cmd_en`, `walk_ok`, `sched_stat` and `req_pend` to 0 at once, without waiting for a clock edge. After `arst_n` rises, all state stays cleared and a write strobe is ignored until SYNC_STAGES rising clock edges have passed.
- R2: On a clock edge where `cmd_wr` is 1, `cmd_en` takes the value of `cmd_wdata`. On an edge where `cmd_wr` is 0, `cmd_en` keeps its value.
- R3: `walk_ok` changes only on a clock edge where `fetch_pt` is 1. A write without a fetch pulse leaves `walk_ok` unchanged.
- R4: On an edge with `fetch_pt` = 1, `walk_ok` takes the written enable. If `cmd_wr` is 1 in that same cycle, the value of `cmd_wdata` in that cycle is the one applied.
- R5: `sched_stat` always equals `walk_ok`. It therefore changes on the same edge at which a new enable is latched.
- R6: `req_pend` is 1 exactly when `cmd_en` differs from `sched_stat`.
- R7: When the enable is written several times between two fetch pulses, only the value present at the pulse is applied. A write sequence that returns to the effective value clears `req_pend` without a pulse.
- R8: A fetch pulse with nothing pending leaves `walk_ok`, `sched_stat` and `cmd_en` unchanged, and `req_pend` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the enable bit |
| cmd_wdata | input | 1 | Enable value being written |
| fetch_pt | input | 1 | One-cycle pulse: the walker is about to fetch the next queue head |
| cmd_en | output | 1 | Written enable, readable back through the command register |
| walk_ok | output | 1 | Effective enable; the walker may use the list address |
| sched_stat | output | 1 | Status bit reporting the enable in force |
| req_pend | output | 1 | A written value is waiting for the next fetch point |

## Verification
The bench builds the block with SYNC_STAGES = 3, which is one stage more than the default. This exposes a multi-edge reset-release window in which a write strobe must be ignored. The stimulus table mixes isolated writes, writes that toggle back and forth between pulses, a write landing in the same cycle as a fetch pulse, and idle pulses. Together these exercise the deferral, the same-cycle priority of new data, and the pending flag in both directions. A directed run then asserts reset while the schedule is enabled, to show that the clear is asynchronous.

// File: rtl/seg_pkg.sv
package seg_pkg;
  // Enable request as seen at the fetch boundary: value to apply and
  // whether it differs from what is currently in force.
  typedef struct packed {
    logic value;
    logic differs;
  } seg_req_t;

  localparam int unsigned SEG_MIN_SYNC = 2;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  localparam int unsigned N = (STAGES < seg_pkg::SEG_MIN_SYNC) ? seg_pkg::SEG_MIN_SYNC : STAGES;

  logic [N-1:0] chain_q;
  logic [N-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[N-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[N-1];

  // R1: internal reset cannot rise while the external one is low
  p_release_r1: assert property (@(posedge clk) !arst_n |-> !rst_n_o);
endmodule

// File: rtl/seg_cmd_reg.sv
module seg_cmd_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic in_force,
  output logic cmd_q,
  output seg_pkg::seg_req_t req_o
);
  logic cmd_d;
  logic cmd_ce;

  always_comb begin
    cmd_ce = wr;
    cmd_d  = wdata;
    // same-cycle write wins at a fetch boundary
    req_o.value   = wr ? wdata : cmd_q;
    req_o.differs = (wr ? wdata : cmd_q) != in_force;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= 1'b0;
    else if (cmd_ce) cmd_q <= cmd_d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cmd_q == $past(wdata));
  p_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cmd_q));
endmodule

// File: rtl/seg_apply.sv
module seg_apply (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_pt,
  input  seg_pkg::seg_req_t req_i,
  output logic eff_q
);
  logic eff_d;
  logic eff_ce;

  always_comb begin
    eff_ce = fetch_pt && req_i.differs;
    eff_d  = req_i.value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      eff_q <= 1'b0;
    else if (eff_ce) eff_q <= eff_d;
  end

  p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_pt |=> $stable(eff_q));
endmodule

// File: rtl/sched_enable_gate.sv
module sched_enable_gate #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cmd_wr,
  input  logic cmd_wdata,
  input  logic fetch_pt,
  output logic cmd_en,
  output logic walk_ok,
  output logic sched_stat,
  output logic req_pend
);
  import seg_pkg::*;

  logic     rst_n;
  logic     eff;
  seg_req_t req;

  seg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n)
  );

  seg_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_wdata),
    .in_force(eff), .cmd_q(cmd_en), .req_o(req)
  );

  seg_apply u_apply (
    .clk(clk), .rst_n(rst_n), .fetch_pt(fetch_pt), .req_i(req), .eff_q(eff)
  );

  assign walk_ok    = eff;
  assign sched_stat = eff;
  assign req_pend   = cmd_en ^ eff;

  p_apply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pt && !cmd_wr |=> walk_ok == $past(cmd_en));
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pt && cmd_wr |=> walk_ok == $past(cmd_wdata));
  p_pend_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pend) |-> $past(cmd_wr));
  p_idle_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pt && !cmd_wr && !req_pend |=> !req_pend && $stable(walk_ok));
  p_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pt |=> !req_pend);
endmodule

// File: tb/sim_sched_enable_gate.sv
module sim_sched_enable_gate;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;
  localparam int NVEC = 14;

  // {req[3:0], wr, wdata, fetch, exp_walk, exp_cmd, exp_pend}
  localparam logic [9:0] VEC [NVEC] = '{
    {4'd2, 3'b110, 3'b011},  // R2 write 1, not yet in force
    {4'd3, 3'b000, 3'b011},  // R3 no pulse, still deferred
    {4'd4, 3'b001, 3'b110},  // R4 pulse applies 1
    {4'd6, 3'b100, 3'b101},  // R6 write 0 -> pending
    {4'd7, 3'b110, 3'b110},  // R7 back to 1, pending clears
    {4'd7, 3'b100, 3'b101},  // R7 write 0 again
    {4'd5, 3'b001, 3'b000},  // R5 pulse, status drops with walk
    {4'd4, 3'b111, 3'b110},  // R4 write and pulse same cycle
    {4'd3, 3'b100, 3'b101},  // R3 write 0, walk stays 1
    {4'd7, 3'b110, 3'b110},  // R7
    {4'd7, 3'b100, 3'b101},  // R7 last value before pulse is 0
    {4'd7, 3'b001, 3'b000},  // R7 only final value applied
    {4'd8, 3'b001, 3'b000},  // R8 idle pulse
    {4'd4, 3'b101, 3'b000}   // R4 write 0 with pulse while off
  };

  logic clk = 1'b0;
  logic arst_n, cmd_wr, cmd_wdata, fetch_pt;
  logic cmd_en, walk_ok, sched_stat, req_pend;
  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_enable_gate #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .arst_n(arst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .fetch_pt(fetch_pt), .cmd_en(cmd_en), .walk_ok(walk_ok),
    .sched_stat(sched_stat), .req_pend(req_pend)
  );

  task automatic check(input int rq, input logic [3:0] act, input logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: {walk,stat,cmd,pend} actual %b expected %b at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive(input logic w, input logic d, input logic f);
    @(negedge clk);
    cmd_wr = w; cmd_wdata = d; fetch_pt = f;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL R0: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = 1'b0; fetch_pt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b0000);
    arst_n = 1'b1;
    // R1 write during synchronous release window is ignored
    cmd_wr = 1'b1; cmd_wdata = 1'b1;
    drive(1'b0, 1'b0, 1'b0);
    repeat (SYNC) @(negedge clk);
    check(1, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b0000);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][5], VEC[i][4], VEC[i][3]);
      @(negedge clk);
      cmd_wr = 1'b0; fetch_pt = 1'b0;
      check(int'(VEC[i][9:6]),
            {walk_ok, sched_stat, cmd_en, req_pend},
            {VEC[i][2], VEC[i][2], VEC[i][1], VEC[i][0]});
    end

    // R1 asynchronous clear while enabled
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b0, 1'b0, 1'b0);
    check(4, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b1110);
    #(CLK_PERIOD/4);
    arst_n = 1'b0;
    #1;
    check(1, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b0000);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    check(1, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b0000);

    // R8 idle pulse after reset
    drive(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    fetch_pt = 1'b0;
    check(8, {walk_ok, sched_stat, cmd_en, req_pend}, 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule